// File: doc/BRIEF.md
# System-Management Interrupt and Clock-Stop Controller

This block collects power-management events from a system and turns them into two CPU-facing signals: an active-low system-management interrupt and an active-low clock-stop request. Eight event sources are available. Each has its own enable bit and its own sticky status bit. Recording an event is kept apart from driving the interrupt: a gate bit decides only whether recorded events reach the interrupt pin. Status bits persist until software clears them by writing ones to them.

A loadable down-counting idle timer counts toward zero. When it reaches zero it raises an expiry event, which is one of the interrupt sources, and it starts counting again on the next clock. Any enabled system activity reloads the timer, and a freeze bit can hold it still. A read strobe on the power-management command port raises the clock-stop request, but only when the clock-stop enable bit is set. Any write strobe on that port clears the enable bit. Enabled system activity also drops the request. In scaling mode the request alternates between an asserted phase and a released phase, and each phase has its own programmable length.

Configuration uses a simple write port: a strobe, a 3-bit register index and a 16-bit data word. Interrupt request lines, the NMI line and the external request line are all edge-detected on their rising transitions.

Top module: `pm_smi_ctrl`

## Requirements
- R1: After reset, `smi_n` and `clkstop_n` are both 1, and the gate, clock-stop enable, scaling and freeze bits are all 0. Control register (index 0) bits: 0 = gate, 1 = clock-stop enable, 2 = scaling, 3 = freeze.
- R2: A rising edge on an enabled source sets that source's status bit on the same clock edge; a disabled source sets nothing. The source bit positions, used in both the enable register (index 1) and the status register (index 2), are: 0 = irq[1], 1 = irq[3], 2 = irq[4], 3 = irq[8], 4 = irq[12], 5 = idle-timer expiry, 6 = ext_smi, 7 = command-port write.
- R3: Writing to index 2 clears exactly the status bits written as 1; other bits stay set. A new event on the same edge takes priority over the clear.
- R4: The gate bit does not affect recording. Events that arrive while the gate is 0 are recorded, and setting the gate with a bit already pending drives `smi_n` low on the edge that writes the gate.
- R5: `smi_n` is 0 exactly while the gate is 1 and at least one status bit is 1.
- R6: Writing N to index 5 loads both the reload value and the count. The count then falls by one per clock, expiry is flagged in the cycle where the count is 0, and the count reloads to N on the next edge. Expiries therefore recur every N+1 cycles.
- R7: While the freeze bit is 1, the count holds and no expiry occurs; clearing the bit resumes counting.
- R8: An enabled system event reloads the count to N. Event-enable bits are set through index 3 (bits 15..0) and index 4 (bits 31..16): bit k for k = 0..15 except 2 is irq[k], bit 29 is the NMI rising edge, bit 31 is `smi_n` becoming asserted, and all other bits are ignored.
- R9: An enabled system event negates an active clock-stop request on the same edge.
- R10: A `cmd_rd` strobe asserts `clkstop_n` low from the next cycle only when the clock-stop enable bit is 1; with the bit at 0 it has no effect.
- R11: A `cmd_wr` strobe clears the clock-stop enable bit, and `clkstop_n` is 1 from the next cycle on until the bit is set again and another `cmd_rd` strobe arrives.
- R12: With scaling on, `clkstop_n` is low for L cycles and then high for H cycles, repeating, where L is the value at index 6 and H is the value at index 7 (a value of 0 acts as 1).
- R13: An irq line held high produces exactly one event; a new event needs a low-then-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | N_IRQ | Interrupt request lines, active high |
| nmi | input | 1 | Non-maskable interrupt line, active high |
| ext_smi | input | 1 | External interrupt request, active high |
| cmd_rd | input | 1 | Single-cycle read strobe of the power-management command port |
| cmd_wr | input | 1 | Single-cycle write strobe of the power-management command port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | DATA_W | Configuration write data |
| smi_n | output | 1 | System-management interrupt, active low |
| clkstop_n | output | 1 | Clock-stop request to the CPU, active low |

## Verification
Every status bit is visible at `smi_n` within one cycle of the edge that changes it. A wrong enable, a wrong clear mask or a lost sticky bit therefore shows up as `smi_n` sitting at the wrong level on the very next sample, and the bench finds out which bit is wrong by clearing bits one at a time. A wrong idle-timer count cannot be seen until the next expiry, so the timer checks sample `smi_n` both one cycle before and exactly on the expected expiry edge. That catches off-by-one load, reload and freeze errors within a single period. A wrong clock-stop phase counter shows as a shifted low/high pattern on `clkstop_n` within one scaled period, and the bench compares that pattern cycle by cycle.

// File: rtl/pmsc_pkg.sv
package pmsc_pkg;

   typedef enum logic [2:0] {
      REG_CTRL    = 3'd0,
      REG_SMI_EN  = 3'd1,
      REG_SMI_STS = 3'd2,
      REG_EVT_LO  = 3'd3,
      REG_EVT_HI  = 3'd4,
      REG_FO_LOAD = 3'd5,
      REG_STP_LO  = 3'd6,
      REG_STP_HI  = 3'd7
   } reg_idx_e;

   localparam int CTRL_W      = 4;
   localparam int CTRL_GATE   = 0;
   localparam int CTRL_STP_EN = 1;
   localparam int CTRL_SCALE  = 2;
   localparam int CTRL_FREEZE = 3;

   localparam int N_SRC      = 8;
   localparam int SRC_IRQ1   = 0;
   localparam int SRC_IRQ3   = 1;
   localparam int SRC_IRQ4   = 2;
   localparam int SRC_IRQ8   = 3;
   localparam int SRC_IRQ12  = 4;
   localparam int SRC_EXPIRE = 5;
   localparam int SRC_EXT    = 6;
   localparam int SRC_CMDWR  = 7;

   localparam int EVT_W   = 32;
   localparam int EVT_NMI = 29;
   localparam int EVT_SMI = 31;
   // bits 0,1,3..15 (irq lines), 29 (nmi), 31 (smi assertion)
   localparam logic [EVT_W-1:0] EVT_VALID = 32'hA000_FFFB;

endpackage

// File: rtl/pmsc_edge.sv
module pmsc_edge #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);

   logic [W-1:0] sampled;
   logic [W-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = din;
      end else begin : g_sync
         logic [W-1:0] stg_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
            end else begin
               stg_q[0] <= din;
               for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign sampled = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sampled;
   end

   assign rise = sampled & ~prev_q;

endmodule

// File: rtl/pmsc_smi_core.sv
module pmsc_smi_core #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_evt,
   input  logic [N-1:0] src_en,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic         gate,
   output logic [N-1:0] status,
   output logic         smi_rise,
   output logic         smi_n
);

   logic [N-1:0] sts_q;
   logic         act;
   logic         act_q;
   logic [N-1:0] clr_bits;

   assign clr_bits = clr_we ? clr_mask : '0;
   assign act      = gate & (|sts_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         act_q <= 1'b0;
      end else begin
         sts_q <= (sts_q & ~clr_bits) | (src_evt & src_en);
         act_q <= act;
      end
   end

   assign status   = sts_q;
   assign smi_rise = act & ~act_q;
   assign smi_n    = ~act;

endmodule

// File: rtl/pmsc_idle_timer.sv
module pmsc_idle_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_we,
   input  logic [W-1:0] load_val,
   input  logic         reload_evt,
   input  logic         freeze,
   output logic         expire
);

   localparam logic [W-1:0] RST_VAL = '1;

   logic [W-1:0] reload_q;
   logic [W-1:0] cnt_q;

   assign expire = (cnt_q == '0) && !freeze && !reload_evt && !load_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RST_VAL;
         cnt_q    <= RST_VAL;
      end else if (load_we) begin
         reload_q <= load_val;
         cnt_q    <= load_val;
      end else if (reload_evt) begin
         cnt_q <= reload_q;
      end else if (!freeze) begin
         if (cnt_q == '0) cnt_q <= reload_q;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pmsc_stop_gen.sv
module pmsc_stop_gen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stop_en,
   input  logic         scale_en,
   input  logic         cmd_rd,
   input  logic         wake_evt,
   input  logic [W-1:0] lo_dur,
   input  logic [W-1:0] hi_dur,
   output logic         clkstop_n
);

   localparam logic [W-1:0] ONE = W'(1);

   logic         stop_q;
   logic         phase_lo_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q     <= 1'b0;
         phase_lo_q <= 1'b1;
         cnt_q      <= ONE;
      end else if (!stop_en || wake_evt) begin
         stop_q     <= 1'b0;
         phase_lo_q <= 1'b1;
      end else if (cmd_rd) begin
         stop_q     <= 1'b1;
         phase_lo_q <= 1'b1;
         cnt_q      <= lo_dur;
      end else if (stop_q) begin
         if (cnt_q <= ONE) begin
            phase_lo_q <= ~phase_lo_q;
            cnt_q      <= phase_lo_q ? hi_dur : lo_dur;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign clkstop_n = ~(stop_q & stop_en & (~scale_en | phase_lo_q));

endmodule

// File: rtl/pm_smi_ctrl.sv
module pm_smi_ctrl
   import pmsc_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int TMR_W       = 16,
   parameter int DUR_W       = 8,
   parameter int N_IRQ       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq,
   input  logic              nmi,
   input  logic              ext_smi,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              smi_n,
   output logic              clkstop_n
);

   localparam int EDGE_W = N_IRQ + 2;
   localparam int LOW_IRQ = 16;

   generate
      if (DATA_W != 16) begin : g_bad_data_w
         $error("DATA_W must be 16");
      end
      if (N_IRQ < 13) begin : g_bad_n_irq
         $error("N_IRQ must be at least 13");
      end
      if (TMR_W < 2 || TMR_W > DATA_W) begin : g_bad_tmr_w
         $error("TMR_W must lie in 2..DATA_W");
      end
      if (DUR_W < 1 || DUR_W > DATA_W) begin : g_bad_dur_w
         $error("DUR_W must lie in 1..DATA_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   // configuration state
   reg_idx_e          wsel;
   logic [CTRL_W-1:0] ctrl_q;
   logic [N_SRC-1:0]  smi_en_q;
   logic [EVT_W-1:0]  evt_en_q;
   logic [DUR_W-1:0]  lo_dur_q;
   logic [DUR_W-1:0]  hi_dur_q;

   assign wsel = reg_idx_e'(cfg_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         smi_en_q <= '0;
         evt_en_q <= '0;
         lo_dur_q <= DUR_W'(1);
         hi_dur_q <= DUR_W'(1);
      end else begin
         if (cfg_we) begin
            case (wsel)
               REG_CTRL:   ctrl_q   <= cfg_wdata[CTRL_W-1:0];
               REG_SMI_EN: smi_en_q <= cfg_wdata[N_SRC-1:0];
               REG_EVT_LO: evt_en_q[DATA_W-1:0] <= cfg_wdata;
               REG_EVT_HI: evt_en_q[EVT_W-1:DATA_W] <= cfg_wdata;
               REG_STP_LO: lo_dur_q <= cfg_wdata[DUR_W-1:0];
               REG_STP_HI: hi_dur_q <= cfg_wdata[DUR_W-1:0];
               default: ;
            endcase
         end
         if (cmd_wr) ctrl_q[CTRL_STP_EN] <= 1'b0;
      end
   end

   // input edge detection
   logic [EDGE_W-1:0] rise_all;
   logic [N_IRQ-1:0]  irq_rise;
   logic              nmi_rise;
   logic              ext_rise;

   pmsc_edge #(.W(EDGE_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ext_smi, nmi, irq}),
      .rise  (rise_all)
   );

   assign irq_rise = rise_all[N_IRQ-1:0];
   assign nmi_rise = rise_all[N_IRQ];
   assign ext_rise = rise_all[N_IRQ+1];

   // interrupt sources
   logic [N_SRC-1:0] src_evt;
   logic             expire;
   logic [N_SRC-1:0] status;
   logic             smi_rise;

   assign src_evt[SRC_IRQ1]   = irq_rise[1];
   assign src_evt[SRC_IRQ3]   = irq_rise[3];
   assign src_evt[SRC_IRQ4]   = irq_rise[4];
   assign src_evt[SRC_IRQ8]   = irq_rise[8];
   assign src_evt[SRC_IRQ12]  = irq_rise[12];
   assign src_evt[SRC_EXPIRE] = expire;
   assign src_evt[SRC_EXT]    = ext_rise;
   assign src_evt[SRC_CMDWR]  = cmd_wr;

   pmsc_smi_core #(.N(N_SRC)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_evt  (src_evt),
      .src_en   (smi_en_q),
      .clr_we   (cfg_we && (wsel == REG_SMI_STS)),
      .clr_mask (cfg_wdata[N_SRC-1:0]),
      .gate     (ctrl_q[CTRL_GATE]),
      .status   (status),
      .smi_rise (smi_rise),
      .smi_n    (smi_n)
   );

   // system activity events
   logic [EVT_W-1:0] evt_raw;
   logic             evt_hit;

   for (genvar g = 0; g < LOW_IRQ; g++) begin : g_evt_irq
      if (g < N_IRQ) begin : g_line
         assign evt_raw[g] = irq_rise[g];
      end else begin : g_none
         assign evt_raw[g] = 1'b0;
      end
   end
   assign evt_raw[EVT_NMI-1:LOW_IRQ] = '0;
   assign evt_raw[EVT_NMI]           = nmi_rise;
   assign evt_raw[EVT_SMI-1]         = 1'b0;
   assign evt_raw[EVT_SMI]           = smi_rise;

   assign evt_hit = |(evt_raw & evt_en_q & EVT_VALID);

   pmsc_idle_timer #(.W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_we    (cfg_we && (wsel == REG_FO_LOAD)),
      .load_val   (cfg_wdata[TMR_W-1:0]),
      .reload_evt (evt_hit),
      .freeze     (ctrl_q[CTRL_FREEZE]),
      .expire     (expire)
   );

   pmsc_stop_gen #(.W(DUR_W)) u_stop (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_en   (ctrl_q[CTRL_STP_EN]),
      .scale_en  (ctrl_q[CTRL_SCALE]),
      .cmd_rd    (cmd_rd),
      .wake_evt  (evt_hit),
      .lo_dur    (lo_dur_q),
      .hi_dur    (hi_dur_q),
      .clkstop_n (clkstop_n)
   );

endmodule

// File: rtl/pm_smi_ctrl_chk.sv
module pm_smi_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       smi_n,
   input logic       clkstop_n,
   input logic       gate,
   input logic       stop_en,
   input logic       freeze,
   input logic       expire,
   input logic [7:0] status,
   input logic       cmd_wr,
   input logic       clr_wr
);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (smi_n && clkstop_n && !gate && !stop_en);
      end
   end

   assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((status & $past(status)) == $past(status)));

   assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |-> smi_n);

   assert_freeze_no_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !expire);

   assert_stop_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_en |-> clkstop_n);

   assert_cmd_wr_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (clkstop_n && !stop_en));

endmodule

bind pm_smi_ctrl pm_smi_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smi_n     (smi_n),
   .clkstop_n (clkstop_n),
   .gate      (ctrl_q[0]),
   .stop_en   (ctrl_q[1]),
   .freeze    (ctrl_q[3]),
   .expire    (expire),
   .status    (status),
   .cmd_wr    (cmd_wr),
   .clr_wr    (cfg_we && (cfg_addr == 3'd2))
);

// File: tb/pm_smi_ctrl_bench.sv
module pm_smi_ctrl_bench;
   import pmsc_pkg::*;

   localparam int N_IRQ = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N_IRQ-1:0]  irq;
   logic              nmi;
   logic              ext_smi;
   logic              cmd_rd;
   logic              cmd_wr;
   logic              cfg_we;
   logic [2:0]        cfg_addr;
   logic [15:0]       cfg_wdata;
   logic              smi_n;
   logic              clkstop_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pm_smi_ctrl u_pm_smi_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (irq),
      .nmi       (nmi),
      .ext_smi   (ext_smi),
      .cmd_rd    (cmd_rd),
      .cmd_wr    (cmd_wr),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .smi_n     (smi_n),
      .clkstop_n (clkstop_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b, expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input reg_idx_e a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_irq(input int i);
      irq[i] = 1'b1;
      @(negedge clk);
      irq[i] = 1'b0;
   endtask

   task automatic pulse_rd();
      cmd_rd = 1'b1; @(negedge clk); cmd_rd = 1'b0;
   endtask

   task automatic pulse_wr();
      cmd_wr = 1'b1; @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 smi_n after reset", smi_n, 1'b1);
      chk("R1 clkstop_n after reset", clkstop_n, 1'b1);
      pulse_rd();
      chk("R1 stop enable is 0 after reset", clkstop_n, 1'b1);
   endtask

   task automatic t_sources();
      wr(REG_SMI_EN, 16'h0002);
      wr(REG_CTRL, 16'h0001);
      pulse_irq(4);
      chk("R2 disabled irq4 source", smi_n, 1'b1);
      pulse_irq(3);
      chk("R2 enabled irq3 source", smi_n, 1'b0);
      wr(REG_SMI_STS, 16'h0002);
      chk("R3 write-one clear", smi_n, 1'b1);
   endtask

   task automatic t_edge();
      irq[3] = 1'b1; tick(1);
      chk("R13 first edge", smi_n, 1'b0);
      wr(REG_SMI_STS, 16'h0002);
      tick(3);
      chk("R13 held level no retrigger", smi_n, 1'b1);
      irq[3] = 1'b0; tick(1);
      irq[3] = 1'b1; tick(1);
      chk("R13 new edge", smi_n, 1'b0);
      irq[3] = 1'b0;
      wr(REG_SMI_STS, 16'h0002);
   endtask

   task automatic t_perbit();
      wr(REG_SMI_EN, 16'h0003);
      pulse_irq(1);
      pulse_irq(3);
      wr(REG_SMI_STS, 16'h0001);
      chk("R3 other bit stays set", smi_n, 1'b0);
      wr(REG_SMI_STS, 16'h0002);
      chk("R5 all clear releases", smi_n, 1'b1);
   endtask

   task automatic t_gate();
      wr(REG_CTRL, 16'h0000);
      pulse_irq(1);
      chk("R4 gate closed", smi_n, 1'b1);
      wr(REG_CTRL, 16'h0001);
      chk("R4 pending event on gate open", smi_n, 1'b0);
      wr(REG_SMI_STS, 16'h00FF);
      chk("R5 released", smi_n, 1'b1);
   endtask

   task automatic t_timer();
      wr(REG_SMI_EN, 16'h0020);
      wr(REG_FO_LOAD, 16'd5);
      tick(5);
      chk("R6 no expiry before count 0", smi_n, 1'b1);
      tick(1);
      chk("R6 expiry", smi_n, 1'b0);
      wr(REG_SMI_STS, 16'h0020);
      tick(4);
      chk("R6 restart no early expiry", smi_n, 1'b1);
      tick(1);
      chk("R6 second expiry", smi_n, 1'b0);
      wr(REG_SMI_EN, 16'h0000);
      wr(REG_SMI_STS, 16'h00FF);
   endtask

   task automatic t_freeze();
      wr(REG_SMI_EN, 16'h0020);
      wr(REG_CTRL, 16'h0009);
      wr(REG_SMI_STS, 16'h00FF);
      tick(20);
      chk("R7 frozen no expiry", smi_n, 1'b1);
      wr(REG_CTRL, 16'h0001);
      tick(8);
      chk("R7 resumes after unfreeze", smi_n, 1'b0);
      wr(REG_SMI_EN, 16'h0000);
      wr(REG_SMI_STS, 16'h00FF);
   endtask

   task automatic t_reload();
      wr(REG_EVT_LO, 16'h0008);
      wr(REG_FO_LOAD, 16'd5);
      wr(REG_SMI_STS, 16'h00FF);
      wr(REG_SMI_EN, 16'h0020);
      tick(1);
      pulse_irq(3);
      tick(5);
      chk("R8 event reload delays expiry", smi_n, 1'b1);
      tick(1);
      chk("R8 expiry after reload", smi_n, 1'b0);
      wr(REG_SMI_EN, 16'h0000);
      wr(REG_SMI_STS, 16'h00FF);
      wr(REG_EVT_LO, 16'h0000);
   endtask

   task automatic t_clkstop();
      wr(REG_CTRL, 16'h0001);
      pulse_rd();
      chk("R10 read without enable", clkstop_n, 1'b1);
      wr(REG_CTRL, 16'h0003);
      pulse_rd();
      chk("R10 read with enable", clkstop_n, 1'b0);
      tick(3);
      chk("R10 stays asserted", clkstop_n, 1'b0);
      wr(REG_EVT_LO, 16'h0002);
      pulse_irq(1);
      chk("R9 system event wakes", clkstop_n, 1'b1);
      pulse_rd();
      chk("R10 asserted again", clkstop_n, 1'b0);
      pulse_wr();
      chk("R11 write releases", clkstop_n, 1'b1);
      pulse_rd();
      chk("R11 enable cleared by write", clkstop_n, 1'b1);
      wr(REG_SMI_EN, 16'h0080);
      pulse_wr();
      chk("R2 command write source", smi_n, 1'b0);
      wr(REG_SMI_EN, 16'h0000);
      wr(REG_SMI_STS, 16'h00FF);
      wr(REG_EVT_LO, 16'h0000);
   endtask

   task automatic t_scale();
      wr(REG_STP_LO, 16'd3);
      wr(REG_STP_HI, 16'd2);
      wr(REG_CTRL, 16'h0007);
      pulse_rd();
      for (int j = 0; j < 10; j++) begin
         chk("R12 scaled pattern", clkstop_n, ((j % 5) < 3) ? 1'b0 : 1'b1);
         tick(1);
      end
      pulse_wr();
   endtask

   initial begin
      rst_n = 1'b0; irq = '0; nmi = 1'b0; ext_smi = 1'b0;
      cmd_rd = 1'b0; cmd_wr = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_sources();
      t_edge();
      t_perbit();
      t_gate();
      t_timer();
      t_freeze();
      t_reload();
      t_clkstop();
      t_scale();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule